// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits between a CPU I/O bus and the configuration space of the device functions. Software reaches a function's configuration dwords in two steps. It first writes a 32-bit locator word to the address port at I/O address 0x0CF8. It then reads or writes through the data port at 0x0CFC. The locator word carries an enable flag in bit 31, a bus number in bits 23:16, a device number in bits 15:11, a function number in bits 10:8 and a dword index in bits 7:2. Each function has 64 dwords: a fixed 16-dword header followed by a 48-dword body.

When the enable flag is set, an access to the data port becomes a transaction on an internal request/response interface. The request side uses a valid/ready handshake. The response carries a claim flag and read data. While the transaction is in flight, the bridge holds the I/O cycle with a wait signal. A read that no function claims returns all ones, and so does a read that times out. Software uses this when it reads dword 0 (vendor ID in bits 15:0, device ID in bits 31:16) to find out whether a function exists. The same data-port path reads the header-type byte, which is byte 2 of dword 3; bit 7 of that byte marks a multi-function device.

An I/O cycle starts with a one-cycle `io_req` pulse and ends with a one-cycle `io_done` pulse that qualifies `io_rdata`. Bus byte enables select the lanes. A byte or word access inside 0x0CFC..0x0CFF is presented with the dword address 0x0CFC and the lanes it covers.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the locator register is zero (enable clear), and `io_wait`, `io_done` and `cfg_req_valid` are low.
- R2: A write to address 0x0CF8 with all four byte enables set stores the locator word. A read of the same form returns the stored word with bits 30:24 and 1:0 reading as 0. Both complete with `io_done` one cycle after the request.
- R3: An access to 0x0CF8..0x0CFB that does not set all four byte enables, or that is not at exactly 0x0CF8, is not decoded. A write leaves the locator unchanged, and a read returns 0xFFFFFFFF.
- R4: While the enable bit is 0, a data-port access issues no request. A read returns 0xFFFFFFFF, a write is dropped, and `io_done` follows one cycle after the request.
- R5: While the enable bit is 1, a data-port access raises `cfg_req_valid` with the locator's bus, device, function and dword fields, the bus write flag and the bus byte enables. The request stays valid and unchanged until `cfg_req_ready` is seen.
- R6: For a claimed read response (`cfg_rsp_hit`=1), `io_rdata` carries `cfg_rsp_rdata` and `io_done` is high in the cycle after the one in which `cfg_rsp_valid` is sampled.
- R7: An unclaimed response (`cfg_rsp_hit`=0) completes the cycle with `io_rdata` equal to 0xFFFFFFFF.
- R8: Byte enable bit k selects data bits 8k+7:8k. A partial data-port write changes only the selected lanes of the target dword.
- R9: If no response completes a transaction within TIMEOUT_CYC cycles, `io_done` rises TIMEOUT_CYC+1 cycles after the request pulse with `io_rdata` = 0xFFFFFFFF. The bridge then accepts new cycles.
- R10: `io_wait` is high in every cycle between the request and `io_done`, and low in the cycle where `io_done` is high.
- R11: An access to any I/O address outside 0x0CF8..0x0CFF completes in one cycle, returns 0xFFFFFFFF and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | One-cycle pulse that starts an I/O cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O byte address |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_done | output | 1 | One-cycle completion pulse |
| io_wait | output | 1 | Holds the I/O cycle while a transaction is in flight |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_req_we | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Bus number |
| cfg_req_dev | output | 5 | Device number |
| cfg_req_fn | output | 3 | Function number |
| cfg_req_dw | output | 6 | Dword index |
| cfg_req_be | output | 4 | Byte-lane enables |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | One-cycle response pulse |
| cfg_rsp_hit | input | 1 | A function claimed the access |
| cfg_rsp_rdata | input | 32 | Read data from the claiming function |

## Verification
The bench counts latency in whole cycles from the request pulse and samples on the falling edge. A cycle that is handled locally (locator access, disabled or undecoded data port, or a foreign address) must show `io_done` at the first falling edge after the pulse. A forwarded cycle must show `io_done` one cycle after the edge that sampled `cfg_rsp_valid`. The bench time-stamps that edge with a rising-edge cycle counter and compares the stamp with the completion cycle. A timed-out cycle must complete exactly TIMEOUT_CYC+1 cycles after the pulse. On every cycle before completion the bench also requires `io_wait` to be high.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [15:0] LOC_PORT  = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;
  localparam logic [31:0] LOC_KEEP  = 32'h80FF_FFFC;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} xfer_st_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_loc_t;
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode #(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic             loc_en,
  output logic             sel_loc,
  output logic             sel_cfg
);
  import cfgb_pkg::*;
  localparam logic [IO_AW-1:0] LOC_A  = IO_AW'(LOC_PORT);
  localparam logic [IO_AW-1:0] DATA_A = IO_AW'(DATA_PORT);

  logic hit_loc_exact;
  logic hit_data_dw;

  always_comb begin
    hit_loc_exact = (io_addr == LOC_A);
    hit_data_dw   = (io_addr[IO_AW-1:2] == DATA_A[IO_AW-1:2]);
    sel_loc       = hit_loc_exact && (io_be == 4'hF);
    sel_cfg       = hit_data_dw && loc_en;
  end
endmodule

// File: rtl/cfgb_loc_reg.sv
module cfgb_loc_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] loc_q
);
  import cfgb_pkg::*;
  logic [31:0] loc_d;

  always_comb begin
    loc_d = loc_q;
    if (wr_en) loc_d = wr_data & LOC_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     loc_q <= '0;
    else if (wr_en) loc_q <= loc_d;
  end

  // R2: locator changes only through a decoded full write
  p_loc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(loc_q));
endmodule

// File: rtl/cfgb_xfer_fsm.sv
module cfgb_xfer_fsm #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_local,
  input  logic [31:0]         local_rdata,
  input  logic                start_cfg,
  input  cfgb_pkg::cfg_loc_t  loc_in,
  input  logic                in_we,
  input  logic [3:0]          in_be,
  input  logic [31:0]         in_wdata,
  output logic                busy,
  output logic                cfg_req_valid,
  input  logic                cfg_req_ready,
  output logic                cfg_req_we,
  output cfgb_pkg::cfg_loc_t  cfg_req_loc,
  output logic [3:0]          cfg_req_be,
  output logic [31:0]         cfg_req_wdata,
  input  logic                cfg_rsp_valid,
  input  logic                cfg_rsp_hit,
  input  logic [31:0]         cfg_rsp_rdata,
  output logic                io_done,
  output logic [31:0]         io_rdata
);
  import cfgb_pkg::*;
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYC - 1);

  xfer_st_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        done_q, done_d;
  logic [31:0] rdata_q, rdata_d;
  logic        cap_en;
  cfg_loc_t    loc_q;
  logic        we_q;
  logic [3:0]  be_q;
  logic [31:0] wdata_q;
  logic        expired;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    cap_en  = 1'b0;
    expired = (cnt_q == TO_LAST);
    unique case (st_q)
      ST_IDLE: begin
        if (start_local) begin
          done_d  = 1'b1;
          rdata_d = local_rdata;
        end else if (start_cfg) begin
          st_d   = ST_REQ;
          cnt_d  = '0;
          cap_en = 1'b1;
        end
      end
      ST_REQ: begin
        if (expired) begin
          st_d = ST_IDLE; done_d = 1'b1; rdata_d = ALL_ONES;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (cfg_req_ready) st_d = ST_RSP;
        end
      end
      ST_RSP: begin
        if (cfg_rsp_valid) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          rdata_d = cfg_rsp_hit ? cfg_rsp_rdata : ALL_ONES;
        end else if (expired) begin
          st_d = ST_IDLE; done_d = 1'b1; rdata_d = ALL_ONES;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      loc_q   <= loc_in;
      we_q    <= in_we;
      be_q    <= in_be;
      wdata_q <= in_wdata;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign cfg_req_valid = (st_q == ST_REQ);
  assign cfg_req_we    = we_q;
  assign cfg_req_loc   = loc_q;
  assign cfg_req_be    = be_q;
  assign cfg_req_wdata = wdata_q;
  assign io_done       = done_q;
  assign io_rdata      = rdata_q;

  // R5: a pending request holds its fields until accepted or timed out
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready && !expired) |=>
      (cfg_req_valid && $stable(cfg_req_loc) && $stable(cfg_req_be) && $stable(cfg_req_wdata)));
  // R9: timeout counter stays inside its window
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TO_LAST);
  // R10: completion never overlaps the wait indication
  p_done_nowait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |-> !busy);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int IO_AW       = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_done,
  output logic             io_wait,
  output logic             cfg_req_valid,
  input  logic             cfg_req_ready,
  output logic             cfg_req_we,
  output logic [7:0]       cfg_req_bus,
  output logic [4:0]       cfg_req_dev,
  output logic [2:0]       cfg_req_fn,
  output logic [5:0]       cfg_req_dw,
  output logic [3:0]       cfg_req_be,
  output logic [31:0]      cfg_req_wdata,
  input  logic             cfg_rsp_valid,
  input  logic             cfg_rsp_hit,
  input  logic [31:0]      cfg_rsp_rdata
);
  import cfgb_pkg::*;

  logic [1:0]  rs_q;
  logic        rst_s_n;
  logic [31:0] loc_word;
  logic        sel_loc, sel_cfg, busy, accept;
  logic        loc_wr, start_local, start_cfg;
  logic [31:0] local_rdata;
  cfg_loc_t    loc_fields, req_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  cfgb_decode #(.IO_AW(IO_AW)) u_dec (
    .io_addr (io_addr),
    .io_be   (io_be),
    .loc_en  (loc_word[31]),
    .sel_loc (sel_loc),
    .sel_cfg (sel_cfg)
  );

  always_comb begin
    accept      = io_req && !busy;
    loc_wr      = accept && io_we && sel_loc;
    start_cfg   = accept && sel_cfg;
    start_local = accept && !sel_cfg;
    local_rdata = (sel_loc && !io_we) ? loc_word : ALL_ONES;
    loc_fields  = '{bus: loc_word[23:16], dev: loc_word[15:11],
                    fn:  loc_word[10:8],  dw:  loc_word[7:2]};
  end

  cfgb_loc_reg u_loc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (loc_wr),
    .wr_data (io_wdata),
    .loc_q   (loc_word)
  );

  cfgb_xfer_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .start_local   (start_local),
    .local_rdata   (local_rdata),
    .start_cfg     (start_cfg),
    .loc_in        (loc_fields),
    .in_we         (io_we),
    .in_be         (io_be),
    .in_wdata      (io_wdata),
    .busy          (busy),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_we    (cfg_req_we),
    .cfg_req_loc   (req_loc),
    .cfg_req_be    (cfg_req_be),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_hit   (cfg_rsp_hit),
    .cfg_rsp_rdata (cfg_rsp_rdata),
    .io_done       (io_done),
    .io_rdata      (io_rdata)
  );

  assign io_wait     = busy;
  assign cfg_req_bus = req_loc.bus;
  assign cfg_req_dev = req_loc.dev;
  assign cfg_req_fn  = req_loc.fn;
  assign cfg_req_dw  = req_loc.dw;

  // R4: no request is ever issued while the locator enable is clear
  p_no_req_disabled_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_req_valid |-> loc_word[31]);
  // R11/R2: a locally handled cycle completes on the next cycle
  p_local_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_local |=> io_done);
endmodule

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
  localparam int TO = 16;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic io_done, io_wait;
  logic cfg_req_valid, cfg_req_we;
  logic cfg_req_ready = 0;
  logic [7:0] cfg_req_bus;
  logic [4:0] cfg_req_dev;
  logic [2:0] cfg_req_fn;
  logic [5:0] cfg_req_dw;
  logic [3:0] cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic cfg_rsp_valid = 0, cfg_rsp_hit = 0;
  logic [31:0] cfg_rsp_rdata = '0;

  cfg_port_bridge #(.IO_AW(16), .TIMEOUT_CYC(TO)) u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target model
  logic [31:0] mem [0:1][0:63];
  int ph = 0, dcnt = 0, rdy_dly = 1, rsp_dly = 1, rsp_cyc = 0;
  bit mute = 0, saw_req = 0;
  logic [7:0] c_bus; logic [4:0] c_dev; logic [2:0] c_fn; logic [5:0] c_dw;
  logic c_we; logic [3:0] c_be; logic [31:0] c_wd;

  function automatic int fidx(logic [7:0] b, logic [4:0] d, logic [2:0] f);
    if (b == 8'h00 && d == 5'd0 && f == 3'd0) return 0;
    if (b == 8'h02 && d == 5'd31 && f == 3'd7) return 1;
    return -1;
  endfunction

  always @(negedge clk) begin
    cfg_req_ready <= 1'b0;
    cfg_rsp_valid <= 1'b0;
    cfg_rsp_hit   <= 1'b0;
    if (cfg_req_valid) saw_req = 1;
    if (ph == 0) begin
      if (cfg_req_valid && !mute) begin
        if (dcnt >= rdy_dly) begin
          cfg_req_ready <= 1'b1;
          c_bus <= cfg_req_bus; c_dev <= cfg_req_dev; c_fn <= cfg_req_fn;
          c_dw <= cfg_req_dw; c_we <= cfg_req_we; c_be <= cfg_req_be; c_wd <= cfg_req_wdata;
          ph <= 1; dcnt <= 0;
        end else dcnt <= dcnt + 1;
      end else dcnt <= 0;
    end else begin
      if (dcnt >= rsp_dly) begin
        int ix;
        ix = fidx(c_bus, c_dev, c_fn);
        cfg_rsp_valid <= 1'b1;
        cfg_rsp_hit   <= (ix >= 0);
        cfg_rsp_rdata <= (ix >= 0) ? mem[ix][c_dw] : 32'h0BAD_0BAD;
        if (ix >= 0 && c_we)
          for (int k = 0; k < 4; k++)
            if (c_be[k]) mem[ix][c_dw][8*k +: 8] = c_wd[8*k +: 8];
        rsp_cyc <= cyc;
        ph <= 0; dcnt <= 0;
      end else dcnt <= dcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_cycle(input logic we, input logic [15:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int lat, output bit wait_ok);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
    @(negedge clk);
    io_req = 0; lat = 1; wait_ok = 1;
    while (!io_done && lat < 400) begin
      if (!io_wait) wait_ok = 0;
      @(negedge clk); lat++;
    end
    if (io_wait) wait_ok = 0;
    rd = io_rdata;
  endtask

  logic [31:0] rd; int lat; bit wok;

  task automatic t_reset;
    chk("R1 wait", {31'b0, io_wait}, 32'd0);
    chk("R1 done", {31'b0, io_done}, 32'd0);
    chk("R1 valid", {31'b0, cfg_req_valid}, 32'd0);
    io_cycle(0, 16'h0CF8, 4'hF, 0, rd, lat, wok);
    chk("R1 locator", rd, 32'd0);
  endtask

  task automatic t_loc_port;
    io_cycle(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, rd, lat, wok);
    chk("R2 write latency", lat, 1);
    io_cycle(0, 16'h0CF8, 4'hF, 0, rd, lat, wok);
    chk("R2 readback masked", rd, 32'h80FF_FFFC);
    chk("R2 read latency", lat, 1);
  endtask

  task automatic t_narrow;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h0001_2300, rd, lat, wok);
    io_cycle(1, 16'h0CF8, 4'h3, 32'hFFFF_FFFF, rd, lat, wok);
    io_cycle(1, 16'h0CFA, 4'hF, 32'hFFFF_FFFF, rd, lat, wok);
    io_cycle(0, 16'h0CF8, 4'hF, 0, rd, lat, wok);
    chk("R3 narrow write ignored", rd, 32'h0001_2300);
    io_cycle(0, 16'h0CF8, 4'h1, 0, rd, lat, wok);
    chk("R3 narrow read ones", rd, ONES);
  endtask

  task automatic t_disabled;
    saw_req = 0;
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R4 read ones", rd, ONES);
    chk("R4 latency", lat, 1);
    io_cycle(1, 16'h0CFC, 4'hF, 32'h1234_5678, rd, lat, wok);
    chk("R4 no request", {31'b0, saw_req}, 32'd0);
    chk("R4 write dropped", mem[0][0], 32'hBEEF_1AB4);
  endtask

  task automatic t_claimed;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h8000_000C, rd, lat, wok);
    rdy_dly = 3; rsp_dly = 2;
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R5 fields bus", {24'b0, c_bus}, 32'h00);
    chk("R5 fields dw", {26'b0, c_dw}, 32'd3);
    chk("R5 be", {28'b0, c_be}, 32'hF);
    chk("R6 header type", rd, 32'h0080_0000);
    chk("R6 multi-function bit", {31'b0, rd[23]}, 32'd1);
    chk("R6 done cycle", cyc, rsp_cyc + 1);
    chk("R10 wait held", {31'b0, wok}, 32'd1);
    rdy_dly = 0; rsp_dly = 0;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h8002_FF00, rd, lat, wok);
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R5 fields dev/fn", {24'b0, c_dev, c_fn}, {24'b0, 5'd31, 3'd7});
    chk("R6 dword0 ids", rd, 32'hC0DE_5A11);
    chk("R6 done cycle fast", cyc, rsp_cyc + 1);
  endtask

  task automatic t_unclaimed;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h8005_0800, rd, lat, wok);
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R7 unclaimed ones", rd, ONES);
    chk("R10 wait unclaimed", {31'b0, wok}, 32'd1);
  endtask

  task automatic t_lanes;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h8000_0014, rd, lat, wok);
    io_cycle(1, 16'h0CFC, 4'b0100, 32'hAABB_CCDD, rd, lat, wok);
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R8 byte lane 2", rd, 32'h11BB_3344);
    io_cycle(1, 16'h0CFC, 4'b0011, 32'h5566_7788, rd, lat, wok);
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R8 low word", rd, 32'h11BB_7788);
  endtask

  task automatic t_timeout;
    io_cycle(1, 16'h0CF8, 4'hF, 32'h8000_0000, rd, lat, wok);
    mute = 1;
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R9 timeout ones", rd, ONES);
    chk("R9 timeout latency", lat, TO + 1);
    chk("R10 wait during timeout", {31'b0, wok}, 32'd1);
    mute = 0;
    repeat (2) @(negedge clk);
    io_cycle(0, 16'h0CFC, 4'hF, 0, rd, lat, wok);
    chk("R9 recovers", rd, 32'hBEEF_1AB4);
  endtask

  task automatic t_foreign;
    io_cycle(1, 16'h03F8, 4'hF, 32'h0, rd, lat, wok);
    io_cycle(0, 16'h0CF8, 4'hF, 0, rd, lat, wok);
    chk("R11 locator untouched", rd, 32'h8000_0000);
    io_cycle(0, 16'h0D00, 4'hF, 0, rd, lat, wok);
    chk("R11 foreign read", rd, ONES);
    chk("R11 latency", lat, 1);
  endtask

  initial begin
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 64; j++) mem[i][j] = 32'h0;
    mem[0][0] = 32'hBEEF_1AB4;
    mem[0][3] = 32'h0080_0000;
    mem[0][5] = 32'h1122_3344;
    mem[1][0] = 32'hC0DE_5A11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_loc_port;
    t_narrow;
    t_disabled;
    t_claimed;
    t_unclaimed;
    t_lanes;
    t_timeout;
    t_foreign;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule